// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns an asynchronous serial line into parallel characters. Software sets the character format through a static control word: 5 to 8 data bits, parity off or on (odd, even or a forced constant bit), and one or two stop bits. An external enable pulses at sixteen times the bit rate. The receiver counts those pulses to find the middle of every bit period. The least significant data bit arrives first. The line input passes through a two-stage synchronizer before the frame logic sees it.

Each finished character updates a byte output and a line status word. In that word, bit 0 is data-ready, bit 2 is parity error, bit 3 is framing error and bit 4 is break. The remaining bits read zero because the block has no queue. The flags are sticky until the host strobes a status read. A data read strobe clears only data-ready. A line status interrupt request is raised while any error flag is set and the interrupt enable input is high.

The frame engine is an enumerated state machine:
- `S_IDLE`: waits for a low sample on an oversampling tick, then goes to `S_START`.
- `S_START`: checks the line again eight ticks later. A high line returns to `S_IDLE`; a low line goes to `S_DATA`.
- `S_DATA`: samples one bit every sixteen ticks. After the last data bit it goes to `S_PARITY` if parity is on, otherwise to `S_STOP`.
- `S_PARITY`: samples the parity bit, then goes to `S_STOP`.
- `S_STOP`: samples the stop bits and delivers the character after the last one. If the line is high at that point it returns to `S_IDLE`; if low, it goes to `S_HOLD`.
- `S_HOLD`: waits for the line to go high, then returns to `S_IDLE`.

Top module: `srx_line_receiver`

## Requirements
- R1: `ctrl_word[1:0]` sets the data length (00=5, 01=6, 10=7, 11=8 bits). The first data bit on the line is bit 0 of `rx_byte`, and bits at or above the length read 0.
- R2: A low level that is gone at the start-bit check, 8 ticks after it was first seen, produces no character and sets no flag.
- R3: With `ctrl_word[3]` set, a parity bit follows the data. `ctrl_word[4]`=1 expects even parity and 0 expects odd parity. A mismatch sets `line_status[2]`.
- R4: With `ctrl_word[3]` and `ctrl_word[5]` both set, the expected parity bit is the inverse of `ctrl_word[4]`, whatever the data.
- R5: `ctrl_word[2]`=0 means one stop bit and 1 means two. Only the first stop bit sampled low sets the framing error flag `line_status[3]`.
- R6: When every sampled bit of a character is low (start, data, parity and stop), the block delivers `rx_byte`=0 with `line_status[4]` and `line_status[3]` set and no parity error. It then waits for the line to go high before looking for a new start.
- R7: Flags in `line_status[4:2]` and data-ready stay set until a `rd_status` pulse, which clears `line_status[4:0]`. A character finishing in the same cycle wins over the clear.
- R8: A `rd_data` pulse clears `line_status[0]` only and leaves the error flags unchanged.
- R9: `line_status` bits 1, 5, 6 and 7 always read 0.
- R10: `lsi_req` is high exactly when `lsi_enable` is high and at least one of `line_status[4:2]` is set.
- R11: Every completed character sets `line_status[0]` and loads `rx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_line | input | 1 | Serial line, idles high |
| ctrl_word | input | 6 | [1:0] length, [2] two stop bits, [3] parity on, [4] even, [5] forced parity |
| lsi_enable | input | 1 | Line status interrupt enable |
| rd_status | input | 1 | Status read strobe, clears flags |
| rd_data | input | 1 | Data read strobe, clears data-ready |
| rx_byte | output | 8 | Last received character |
| line_status | output | 8 | Status word (bit0 ready, bit2 parity, bit3 framing, bit4 break) |
| lsi_req | output | 1 | Line status interrupt request |

## Verification
Characters are sent in four formats: all 8 bit lengths with no parity, a 5-bit length carrying high bits that must be dropped, odd and even parity, and the forced-parity mode with both polarities. Each format is sent once with a correct parity bit and once with it flipped, which separates the parity equation from the plain data path. Stop-bit patterns tell the first stop bit apart from the second. All-low frames in two formats check break against an ordinary framing error. A short start glitch and separate data and status read strobes show which flags each strobe clears.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_HOLD
    } rx_state_t;

    // Field order mirrors ctrl_word[5:0]
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len_code;
    } rx_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_result_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  rx_cfg_t    cfg,
    output logic       done,
    output rx_result_t res
);
    localparam int CW       = $clog2(OSR);
    localparam int IW       = $clog2(DW + 1);
    localparam int MIN_BITS = DW - 3;
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] sh;
    logic          zeros, par_bad, ferr_q, stop2;

    logic [IW-1:0] nbits;
    logic [DW-1:0] data_al;
    logic          bit_at, last_data, last_stop, exp_par, fe_now, brk_now;

    always_comb begin
        nbits     = IW'(MIN_BITS) + IW'(cfg.len_code);
        bit_at    = tick && (cnt == LAST);
        last_data = (idx == nbits - IW'(1));
        last_stop = !cfg.two_stop || stop2;
        data_al   = sh >> (IW'(DW) - nbits);
        if (cfg.stick) exp_par = !cfg.even;
        else           exp_par = cfg.even ? (^data_al) : !(^data_al);
        fe_now    = stop2 ? ferr_q : !rx;
        brk_now   = zeros && !rx;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (tick && !rx) nxt = S_START;
            S_START:  if (tick && cnt == MID) nxt = rx ? S_IDLE : S_DATA;
            S_DATA:   if (bit_at && last_data) nxt = cfg.par_en ? S_PARITY : S_STOP;
            S_PARITY: if (bit_at) nxt = S_STOP;
            S_STOP:   if (bit_at && last_stop) nxt = rx ? S_IDLE : S_HOLD;
            S_HOLD:   if (rx) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            sh      <= '0;
            zeros   <= 1'b1;
            par_bad <= 1'b0;
            ferr_q  <= 1'b0;
            stop2   <= 1'b0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    cnt     <= '0;
                    idx     <= '0;
                    zeros   <= 1'b1;
                    par_bad <= 1'b0;
                    ferr_q  <= 1'b0;
                    stop2   <= 1'b0;
                end
                S_START: begin
                    if (tick) cnt <= (cnt == MID) ? '0 : cnt + 1'b1;
                end
                S_DATA: begin
                    if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    if (bit_at) begin
                        sh    <= {rx, sh[DW-1:1]};
                        idx   <= idx + 1'b1;
                        zeros <= zeros & !rx;
                    end
                end
                S_PARITY: begin
                    if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    if (bit_at) begin
                        par_bad <= rx ^ exp_par;
                        zeros   <= zeros & !rx;
                    end
                end
                S_STOP: begin
                    if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    if (bit_at) begin
                        zeros <= zeros & !rx;
                        if (!stop2) ferr_q <= !rx;
                        if (last_stop) begin
                            done     <= 1'b1;
                            res.brk  <= brk_now;
                            res.data <= brk_now ? '0 : data_al;
                            res.perr <= par_bad && !brk_now;
                            res.ferr <= fe_now;
                        end else begin
                            stop2 <= 1'b1;
                        end
                    end
                end
                S_HOLD: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srx_status_reg.sv
module srx_status_reg
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  rx_result_t res,
    input  logic       rd_status,
    input  logic       rd_data,
    input  logic       irq_en,
    output logic [7:0] data_q,
    output logic [7:0] lsr,
    output logic       irq
);
    logic dr, pe, fe, bi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dr     <= 1'b0;
            pe     <= 1'b0;
            fe     <= 1'b0;
            bi     <= 1'b0;
        end else begin
            if (done) data_q <= res.data;
            dr <= (dr & !rd_status & !rd_data) | done;
            pe <= (pe & !rd_status) | (done & res.perr);
            fe <= (fe & !rd_status) | (done & res.ferr);
            bi <= (bi & !rd_status) | (done & res.brk);
        end
    end

    assign lsr = {3'b000, bi, fe, pe, 1'b0, dr};
    assign irq = irq_en & (pe | fe | bi);
endmodule

// File: rtl/srx_line_receiver.sv
module srx_line_receiver
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [5:0] ctrl_word,
    input  logic       lsi_enable,
    input  logic       rd_status,
    input  logic       rd_data,
    output logic [7:0] rx_byte,
    output logic [7:0] line_status,
    output logic       lsi_req
);
    logic       rx_s;
    logic       frame_done;
    rx_result_t frame_res;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_s)
    );

    srx_frame_fsm #(.OSR(OSR), .DW(8)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .rx    (rx_s),
        .cfg   (rx_cfg_t'(ctrl_word)),
        .done  (frame_done),
        .res   (frame_res)
    );

    srx_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frame_done),
        .res       (frame_res),
        .rd_status (rd_status),
        .rd_data   (rd_data),
        .irq_en    (lsi_enable),
        .data_q    (rx_byte),
        .lsr       (line_status),
        .irq       (lsi_req)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ctrl_word,
    input logic       lsi_enable,
    input logic       rd_status,
    input logic       rd_data,
    input logic       frame_done,
    input logic [7:0] rx_byte,
    input logic [7:0] line_status,
    input logic       lsi_req
);
    p_len_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[0] |-> ((rx_byte >> (4'd5 + {2'b00, ctrl_word[1:0]})) == 8'd0));

    p_break_fe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[4] |-> line_status[3]);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !frame_done) |=> (line_status[4:0] == 5'd0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_status[3] && !rd_status) |=> line_status[3]);

    p_rddata_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !frame_done) |=> !line_status[0]);

    p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_status[7:5] == 3'd0) && !line_status[1]);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lsi_enable |-> !lsi_req);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lsi_req |-> (|line_status[4:2]));

    p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> line_status[0]);
endmodule

bind srx_line_receiver srx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_word   (ctrl_word),
    .lsi_enable  (lsi_enable),
    .rd_status   (rd_status),
    .rd_data     (rd_data),
    .frame_done  (frame_done),
    .rx_byte     (rx_byte),
    .line_status (line_status),
    .lsi_req     (lsi_req)
);

// File: tb/sim_srx_line_receiver.sv
module sim_srx_line_receiver;
    localparam int TICK_DIV = 4;
    localparam int OSR      = 16;
    localparam int BIT_CLKS = TICK_DIV * OSR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [5:0] ctrl_word = 6'd0;
    logic       lsi_enable = 1'b0;
    logic       rd_status_t = 1'b0;
    logic       rd_status_m = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status;
    logic [7:0] rx_byte, line_status;
    logic       lsi_req;

    int  checks = 0;
    int  errors = 0;
    bit  mon_en = 1'b0;
    bit  finished = 1'b0;
    logic [10:0] exp_q[$];
    string       tag_q[$];

    assign rd_status = rd_status_t | rd_status_m;

    always #10 clk = ~clk;

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV - 1);
    end

    srx_line_receiver u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx_line     (rx_line),
        .ctrl_word   (ctrl_word),
        .lsi_enable  (lsi_enable),
        .rd_status   (rd_status),
        .rd_data     (rd_data),
        .rx_byte     (rx_byte),
        .line_status (line_status),
        .lsi_req     (lsi_req)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // driver: expected item = {data, pe, fe, bi}
    task automatic send_char(input logic [7:0] d, input bit bad_par,
                             input bit s1, input bit s2, input string tag);
        int         n;
        logic [7:0] m;
        logic       ones, pbit;
        n    = 5 + int'(ctrl_word[1:0]);
        m    = 8'hFF >> (8 - n);
        ones = ^(d & m);
        if (ctrl_word[5]) pbit = !ctrl_word[4];
        else              pbit = ctrl_word[4] ? ones : !ones;
        if (bad_par) pbit = !pbit;
        if (mon_en) begin
            exp_q.push_back({d & m, ctrl_word[3] & bad_par, !s1, 1'b0});
            tag_q.push_back(tag);
        end
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(d[i]);
        if (ctrl_word[3]) drive_bit(pbit);
        drive_bit(s1);
        if (ctrl_word[2]) drive_bit(s2);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic send_break(input string tag);
        int lows;
        lows = 1 + 5 + int'(ctrl_word[1:0]) + int'(ctrl_word[3])
             + (ctrl_word[2] ? 2 : 1) + 1;
        exp_q.push_back({8'h00, 1'b0, 1'b1, 1'b1});
        tag_q.push_back(tag);
        for (int i = 0; i < lows; i++) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic pulse_rd_data();
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
    endtask

    task automatic pulse_rd_status();
        @(negedge clk) rd_status_t = 1'b1;
        @(negedge clk) rd_status_t = 1'b0;
    endtask

    // monitor: pops expected items as characters appear
    logic prev_dr = 1'b0;
    bit   pend = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            rd_status_m <= 1'b0;
            pend        <= 1'b0;
            check_eq("R7", "flags after status read", 16'(line_status[4:0]), 16'h0);
        end else if (mon_en && line_status[0] && !prev_dr) begin
            if (exp_q.size() == 0) begin
                check_eq("R11", "unexpected character", 16'h1, 16'h0);
            end else begin
                logic [10:0] e;
                string       t;
                logic        any_err;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                any_err = e[2] | e[1] | e[0];
                check_eq({"R1 ", t}, "rx_byte", 16'(rx_byte), 16'(e[10:3]));
                check_eq({"R9 ", t}, "line_status", 16'(line_status),
                         16'({3'b000, e[0], e[1], e[2], 1'b0, 1'b1}));
                check_eq({"R10 ", t}, "lsi_req", 16'(lsi_req), 16'(lsi_enable & any_err));
            end
            rd_status_m <= 1'b1;
            pend        <= 1'b1;
        end
        prev_dr <= line_status[0];
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R9", "reset line_status", 16'(line_status), 16'h0);
        check_eq("R11", "reset rx_byte", 16'(rx_byte), 16'h0);
        check_eq("R10", "reset lsi_req", 16'(lsi_req), 16'h0);
        repeat (2) drive_bit(1'b1);

        mon_en = 1'b1;
        // R1/R11: 8 bits, no parity, one stop
        ctrl_word = 6'b000011;
        send_char(8'hA5, 0, 1, 1, "8N1 A5");
        send_char(8'h00, 0, 1, 1, "8N1 00");
        send_char(8'hFF, 0, 1, 1, "8N1 FF");
        // R1: 5 bits, upper bits must drop
        ctrl_word = 6'b000000;
        send_char(8'hFB, 0, 1, 1, "5N1 len mask");
        // R3: 6 bits odd parity, R10 enabled
        lsi_enable = 1'b1;
        ctrl_word = 6'b001001;
        send_char(8'h2A, 0, 1, 1, "R3 6O1 good");
        send_char(8'h2A, 1, 1, 1, "R3 6O1 bad");
        // R3: 7 bits even parity
        ctrl_word = 6'b011010;
        send_char(8'h35, 0, 1, 1, "R3 7E1 good");
        send_char(8'h35, 1, 1, 1, "R3 7E1 bad");
        // R4: forced parity, even select -> expect 0
        ctrl_word = 6'b111011;
        send_char(8'hC3, 0, 1, 1, "R4 stick0 good");
        send_char(8'hC3, 1, 1, 1, "R4 stick0 bad");
        // R4: forced parity, odd select -> expect 1
        ctrl_word = 6'b101011;
        send_char(8'h3C, 0, 1, 1, "R4 stick1 good");
        send_char(8'h3C, 1, 1, 1, "R4 stick1 bad");
        // R5: two stop bits
        lsi_enable = 1'b0;
        ctrl_word = 6'b000111;
        send_char(8'h5A, 0, 1, 0, "R5 second stop low");
        send_char(8'h5A, 0, 0, 1, "R5 first stop low");
        // R6: break in two formats
        lsi_enable = 1'b1;
        ctrl_word = 6'b000011;
        send_break("R6 break 8N1");
        ctrl_word = 6'b011110;
        send_break("R6 break 7E2");
        // R2: start glitch
        ctrl_word = 6'b000011;
        rx_line = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (3) drive_bit(1'b1);
        check_eq("R2", "glitch line_status", 16'(line_status), 16'h0);
        check_eq("R11", "pending expected items", 16'(exp_q.size()), 16'h0);

        // directed strobe checks
        mon_en = 1'b0;
        lsi_enable = 1'b0;
        repeat (4) @(negedge clk);
        send_char(8'h3C, 0, 1, 1, "direct");
        check_eq("R11", "ready set", 16'(line_status), 16'h01);
        check_eq("R11", "byte loaded", 16'(rx_byte), 16'h3C);
        pulse_rd_data();
        check_eq("R8", "rd_data clears ready", 16'(line_status), 16'h00);
        lsi_enable = 1'b1;
        send_char(8'h3C, 0, 0, 1, "direct fe");
        check_eq("R5", "framing status", 16'(line_status), 16'h09);
        check_eq("R10", "irq with fe", 16'(lsi_req), 16'h1);
        pulse_rd_data();
        check_eq("R8", "rd_data keeps fe", 16'(line_status), 16'h08);
        lsi_enable = 1'b0;
        @(negedge clk);
        check_eq("R10", "irq gated", 16'(lsi_req), 16'h0);
        pulse_rd_status();
        check_eq("R7", "rd_status clears", 16'(line_status), 16'h00);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule